// File: doc/BRIEF.md
# Bus Interrupt and Reset Controller

This block connects a host CPU to an expansion bus. Through a small register port, software holds or releases the bus reset line. The block also collects two active-low signals from bus devices: a shared interrupt line and a system-error line. Both lines are combined outside the block.

The two sources are captured in different ways. The interrupt line is level-sensitive, so its status bit follows the line while the line is low. The system-error line is edge-sensitive: a falling edge sets a sticky status bit, and software clears that bit by writing 1 to it. Each status bit has its own enable bit. The CPU interrupt output is a registered OR of the enabled status bits.

The register map is:
- address 0, control: bit 0 holds the bus in reset.
- address 1, status: bit 0 is the interrupt level (read-only), bit 1 is the system-error flag (write 1 to clear).
- address 2, enable: bit 0 enables the interrupt level, bit 1 enables the system-error flag.

Reads of any other address, and of unused bits, return 0.

Top module: `busirq_rst_ctrl`

## Requirements
- R1: After reset the control register reads 1 and `bus_rst_n` is low. The enable register reads 0, the status register reads 0 and `cpu_irq` is low.
- R2: `bus_rst_n` is the inverse of control bit 0 and changes on the clock edge of the write to address 0. It stays low until software writes that bit to 0.
- R3: Status bit 0 is 1 while `dev_irq_n` is low and 0 while it is high. It follows the pin with two cycles of latency from the synchronizer. Writes to status bit 0 have no effect on it.
- R4: A falling edge on `dev_err_n` sets status bit 1 three clock edges after the pin falls (two synchronizer stages plus the edge detector). The bit stays set. Holding the pin low does not set the bit again after a clear.
- R5: Writing 1 to status bit 1 clears it. Writing 0 to it leaves it unchanged.
- R6: If a system-error edge and a clear of status bit 1 take effect on the same edge, the bit stays set.
- R7: `cpu_irq` equals, one cycle later, the OR over both sources of (status bit AND enable bit). A source whose enable bit is 0 never raises it.
- R8: The control register sits at address 0, the status register at address 1 and the enable register at address 2, with bit positions as given above. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational from address) |
| dev_irq_n | input | 1 | Shared device interrupt, active low, level-sensitive |
| dev_err_n | input | 1 | Device system-error, active low, edge-sensitive |
| bus_rst_n | output | 1 | Bus reset, active low |
| cpu_irq | output | 1 | Registered interrupt to the CPU |

## Verification
The clear of the sticky system-error bit by software and a new falling edge on the error line can land on the same clock edge. The bench makes this happen by lowering `dev_err_n` and then presenting a write-1 to status bit 1 exactly two cycles later, so that the write edge is the one where the detected edge sets the flag. Status must still read 1 after that edge. A clear made one cycle later must then succeed.

// File: rtl/busirq_rst_ctrl.sv
module busirq_rst_ctrl #(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dev_irq_n,
  input  logic              dev_err_n,
  output logic              bus_rst_n,
  output logic              cpu_irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(2);

  logic [SYNC_STAGES-1:0] irq_sync, err_sync;
  logic       hold_q, err_prev_q, err_sts_q, irq_q;
  logic [1:0] en_q;

  wire lvl_sts  = ~irq_sync[SYNC_STAGES-1];
  wire err_fall = err_prev_q & ~err_sync[SYNC_STAGES-1];
  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire wr_stat  = reg_wr && reg_addr == A_STAT;
  wire wr_mask  = reg_wr && reg_addr == A_MASK;
  wire unused_wdata = ^reg_wdata[DATA_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sync   <= '1;
      err_sync   <= '1;
      err_prev_q <= 1'b1;
      hold_q     <= 1'b1;
      en_q       <= '0;
      err_sts_q  <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_sync   <= {irq_sync[SYNC_STAGES-2:0], dev_irq_n};
      err_sync   <= {err_sync[SYNC_STAGES-2:0], dev_err_n};
      err_prev_q <= err_sync[SYNC_STAGES-1];
      if (wr_ctrl) hold_q <= reg_wdata[0];
      if (wr_mask) en_q <= reg_wdata[1:0];
      err_sts_q  <= err_fall | (err_sts_q & ~(wr_stat & reg_wdata[1]));
      irq_q      <= |({err_sts_q, lvl_sts} & en_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[0]   = hold_q;
      A_STAT:  reg_rdata[1:0] = {err_sts_q, lvl_sts};
      A_MASK:  reg_rdata[1:0] = en_q;
      default: reg_rdata      = '0;
    endcase
  end

  assign bus_rst_n = ~hold_q;
  assign cpu_irq   = irq_q;
endmodule

// File: rtl/busirq_rst_ctrl_chk.sv
module busirq_rst_ctrl_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              bus_rst_n,
  input logic              cpu_irq,
  input logic              lvl_sts,
  input logic              err_sts_q,
  input logic              err_fall,
  input logic [1:0]        en_q
);
  wire wr0 = reg_wr && reg_addr == ADDR_W'(0);
  wire clr = reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[1];

  AST_BUS_RST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 |=> bus_rst_n == !$past(reg_wdata[0])); // R2
  AST_BUS_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr0 |=> $stable(bus_rst_n)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_sts_q && !clr |=> err_sts_q); // R4
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !err_fall |=> !err_sts_q); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr && err_fall |=> err_sts_q); // R6
  AST_IRQ_REG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cpu_irq == $past(|({err_sts_q, lvl_sts} & en_q))); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == 2'b00 |=> !cpu_irq); // R7
endmodule

bind busirq_rst_ctrl busirq_rst_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .bus_rst_n(bus_rst_n), .cpu_irq(cpu_irq),
  .lvl_sts(lvl_sts), .err_sts_q(err_sts_q), .err_fall(err_fall), .en_q(en_q)
);

// File: tb/busirq_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module busirq_rst_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       dev_irq_n = 1'b1;
  logic       dev_err_n = 1'b1;
  logic       bus_rst_n, cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int sel; logic [7:0] exp; string tag; } item_t;
  item_t expq[$];

  busirq_rst_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_irq_n(dev_irq_n),
    .dev_err_n(dev_err_n), .bus_rst_n(bus_rst_n), .cpu_irq(cpu_irq)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    #1;
    while (expq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = expq.pop_front();
      act = (it.sel == 0) ? reg_rdata : (it.sel == 1) ? {7'd0, cpu_irq} : {7'd0, bus_rst_n};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.sel = 0; it.exp = e; it.tag = tag;
    expq.push_back(it);
  endtask

  task automatic exp_pin(input int sel, input logic e, input string tag);
    item_t it;
    it.sel = sel; it.exp = {7'd0, e}; it.tag = tag;
    expq.push_back(it);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    exp_rd(2'd0, 8'h01, "R1 ctrl"); exp_pin(2, 1'b0, "R1 bus_rst_n"); exp_pin(1, 1'b0, "R1 cpu_irq");
    tick(1); exp_rd(2'd1, 8'h00, "R1 status");
    tick(1); exp_rd(2'd2, 8'h00, "R1 enable");
    tick(1); exp_rd(2'd3, 8'h00, "R8 unused address");

    wr(2'd0, 8'h00); exp_rd(2'd0, 8'h00, "R2 ctrl cleared"); exp_pin(2, 1'b1, "R2 release");
    tick(5); exp_pin(2, 1'b1, "R2 stays released");
    wr(2'd0, 8'h01); exp_pin(2, 1'b0, "R2 reassert");
    tick(4); exp_pin(2, 1'b0, "R2 held");
    wr(2'd0, 8'h00); exp_pin(2, 1'b1, "R2 release again");

    tick(1); dev_irq_n = 1'b0;
    tick(1); exp_rd(2'd1, 8'h00, "R3 sync latency");
    tick(1); exp_rd(2'd1, 8'h01, "R3 level seen"); exp_pin(1, 1'b0, "R7 masked level");
    wr(2'd2, 8'h01); exp_rd(2'd2, 8'h01, "R8 enable readback");
    tick(1); exp_pin(1, 1'b1, "R7 level enabled");
    wr(2'd1, 8'h01); exp_rd(2'd1, 8'h01, "R3 write ignored");
    dev_irq_n = 1'b1;
    tick(2); exp_rd(2'd1, 8'h00, "R3 level released"); exp_pin(1, 1'b1, "R7 one-cycle lag");
    tick(1); exp_pin(1, 1'b0, "R7 drop");

    dev_err_n = 1'b0;
    tick(2); exp_rd(2'd1, 8'h00, "R4 not yet");
    tick(1); exp_rd(2'd1, 8'h02, "R4 edge latched"); exp_pin(1, 1'b0, "R7 error masked");
    wr(2'd1, 8'h00); exp_rd(2'd1, 8'h02, "R5 write zero");
    wr(2'd1, 8'h02); exp_rd(2'd1, 8'h00, "R5 clear");
    tick(4); exp_rd(2'd1, 8'h00, "R4 no retrigger while low");
    dev_err_n = 1'b1;
    tick(4); exp_rd(2'd1, 8'h00, "R4 rising edge ignored");

    wr(2'd2, 8'h03);
    dev_err_n = 1'b0;
    tick(3); exp_rd(2'd1, 8'h02, "R4 second edge");
    tick(1); exp_pin(1, 1'b1, "R7 error enabled");
    wr(2'd1, 8'h02); exp_rd(2'd1, 8'h00, "R5 clear enabled"); exp_pin(1, 1'b1, "R7 lag");
    tick(1); exp_pin(1, 1'b0, "R7 error dropped");
    dev_err_n = 1'b1;
    tick(4);

    dev_err_n = 1'b0;
    tick(2);
    reg_addr = 2'd1; reg_wdata = 8'h02; reg_wr = 1'b1;
    tick(1); reg_wr = 1'b0;
    exp_rd(2'd1, 8'h02, "R6 set wins");
    wr(2'd1, 8'h02); exp_rd(2'd1, 8'h00, "R6 later clear");
    dev_err_n = 1'b1;
    tick(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule